// File: doc/BRIEF.md
# Packed Multiply and Sum-of-Absolute-Differences Unit

This block is a single-stage datapath for packed arithmetic on two 64-bit operands. Each operand is viewed as four 16-bit lanes or, for one operation, eight byte lanes. A 3-bit operation code picks one of six functions:

- pairwise multiply-add
- low-half lane multiply
- high-half lane multiply
- a four-lane multiply-accumulate reduction
- byte sum of absolute differences
- halfword sum of absolute differences

A separate sign bit chooses whether the multiply operations treat lanes as two's-complement or unsigned values.

An issuing pipeline presents operands, an operation code and a valid bit in one cycle. The result and an output valid flag appear after the next rising clock edge. The block has no stall or handshake. The result register loads only on valid cycles and holds its value otherwise.

Top module: `pmsad_unit`

## Requirements
- R1: Multiply-add (op code 0) adds the products of lanes 0 and 1 into result bits 31:0, and the products of lanes 2 and 3 into bits 63:32. Each sum is truncated to 32 bits. Lane i occupies operand bits 16i+15:16i.
- R2: With the sign bit at 1, every multiply operation (codes 0 to 3) sign-extends each 16-bit lane before multiplying. With the sign bit at 0, it zero-extends each lane.
- R3: Multiply-low (op code 1) places bits 15:0 of each lane product in the same lane of the result.
- R4: Multiply-high (op code 2) places bits 31:16 of each lane product in the same lane of the result.
- R5: Multiply-accumulate (op code 3) returns the sum of all four lane products as one 64-bit value. In signed form the total is sign-extended, and in unsigned form it is zero-extended.
- R6: Byte SAD (op code 4) returns the sum of the absolute differences of the eight unsigned byte pairs, zero-extended to 64 bits. The sign bit has no effect on it.
- R7: Halfword SAD (op code 5) returns the sum of the absolute differences of the four unsigned 16-bit pairs, zero-extended to 64 bits. The sign bit has no effect on it.
- R8: Op codes 6 and 7 are reserved and load a result of zero.
- R9: The result of a valid cycle appears after the next rising edge, and out_valid is high in exactly the cycle that follows a cycle with in_valid high.
- R10: While in_valid is low, result keeps its last loaded value regardless of the operands and op code.
- R11: While rst_n is low, out_valid is 0 and result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and op code are valid this cycle |
| op | input | 3 | Operation code (0 to 5; 6 and 7 reserved) |
| signed_sel | input | 1 | 1 = signed lanes for multiply operations |
| a | input | 64 | First packed operand |
| b | input | 64 | Second packed operand |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 64 | Registered result |

## Verification
The bench builds the unit with its default geometry of four 16-bit lanes over a 64-bit word. At this width the extreme lane values 0x8000 and 0xFFFF are cheap to drive. They reach the cases where signed and unsigned interpretations split. They also reach the 32-bit truncation of a pairwise sum and the carry of the reduction past bit 32. The byte and halfword SAD totals can likewise be driven to their maxima of 0x7F8 and 0x3FFFC. Random operands for every op code and both sign settings are compared against a model the bench computes with native integer casts.

// File: rtl/pmsad_pkg.sv
package pmsad_pkg;
  localparam int LANE_W = 16;
  localparam int LANES  = 4;
  localparam int DATA_W = LANE_W * LANES;
  localparam int PROD_W = 2 * LANE_W;
  localparam int BYTE_W = 8;
  localparam int BYTES  = DATA_W / BYTE_W;
  localparam int PAIRS  = LANES / 2;
  localparam int BSAD_W = BYTE_W + $clog2(BYTES);
  localparam int HSAD_W = LANE_W + $clog2(LANES);
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_MADD  = 3'd0,
    OP_MULLO = 3'd1,
    OP_MULHI = 3'd2,
    OP_MAC   = 3'd3,
    OP_SADB  = 3'd4,
    OP_SADH  = 3'd5
  } op_e;

  // Lane product, widened to the full data word with sign or zero fill.
  function automatic logic [DATA_W-1:0] ext_product(input logic [LANE_W-1:0] x,
                                                    input logic [LANE_W-1:0] y,
                                                    input logic sgn);
    logic [PROD_W-1:0] xe, ye, p;
    xe = {{LANE_W{sgn & x[LANE_W-1]}}, x};
    ye = {{LANE_W{sgn & y[LANE_W-1]}}, y};
    p  = xe * ye;
    return {{(DATA_W-PROD_W){sgn & p[PROD_W-1]}}, p};
  endfunction

  function automatic logic [BYTE_W-1:0] abs_diff_b(input logic [BYTE_W-1:0] x,
                                                   input logic [BYTE_W-1:0] y);
    return (x > y) ? (x - y) : (y - x);
  endfunction

  function automatic logic [LANE_W-1:0] abs_diff_h(input logic [LANE_W-1:0] x,
                                                   input logic [LANE_W-1:0] y);
    return (x > y) ? (x - y) : (y - x);
  endfunction
endpackage

// File: rtl/pmsad_lane_mul.sv
module pmsad_lane_mul
  import pmsad_pkg::*;
(
  input  logic [LANE_W-1:0] x,
  input  logic [LANE_W-1:0] y,
  input  logic              sgn,
  output logic [DATA_W-1:0] prod_ext
);
  assign prod_ext = ext_product(x, y, sgn);
endmodule

// File: rtl/pmsad_sad.sv
module pmsad_sad
  import pmsad_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [BSAD_W-1:0] byte_sum,
  output logic [HSAD_W-1:0] half_sum
);
  logic [BYTES-1:0][BYTE_W-1:0] bdiff;
  logic [LANES-1:0][LANE_W-1:0] hdiff;

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    assign bdiff[g] = abs_diff_b(a[g*BYTE_W +: BYTE_W], b[g*BYTE_W +: BYTE_W]);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_half
    assign hdiff[g] = abs_diff_h(a[g*LANE_W +: LANE_W], b[g*LANE_W +: LANE_W]);
  end

  always_comb begin
    byte_sum = '0;
    for (int i = 0; i < BYTES; i++) byte_sum = byte_sum + BSAD_W'(bdiff[i]);
  end

  always_comb begin
    half_sum = '0;
    for (int i = 0; i < LANES; i++) half_sum = half_sum + HSAD_W'(hdiff[i]);
  end
endmodule

// File: rtl/pmsad_select.sv
module pmsad_select
  import pmsad_pkg::*;
(
  input  logic [OP_W-1:0]              op,
  input  logic [LANES-1:0][DATA_W-1:0] lane_prod,
  input  logic [BSAD_W-1:0]            byte_sum,
  input  logic [HSAD_W-1:0]            half_sum,
  output logic [DATA_W-1:0]            next_result,
  output logic                         op_reserved
);
  logic [DATA_W-1:0] madd_res, lo_res, hi_res, mac_res;

  always_comb begin
    for (int p = 0; p < PAIRS; p++) begin
      madd_res[p*PROD_W +: PROD_W] = lane_prod[2*p][PROD_W-1:0]
                                   + lane_prod[2*p+1][PROD_W-1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lo_res[i*LANE_W +: LANE_W] = lane_prod[i][LANE_W-1:0];
      hi_res[i*LANE_W +: LANE_W] = lane_prod[i][PROD_W-1:LANE_W];
    end
  end

  always_comb begin
    mac_res = '0;
    for (int i = 0; i < LANES; i++) mac_res = mac_res + lane_prod[i];
  end

  always_comb begin
    op_reserved = 1'b0;
    case (op)
      OP_MADD:  next_result = madd_res;
      OP_MULLO: next_result = lo_res;
      OP_MULHI: next_result = hi_res;
      OP_MAC:   next_result = mac_res;
      OP_SADB:  next_result = {{(DATA_W-BSAD_W){1'b0}}, byte_sum};
      OP_SADH:  next_result = {{(DATA_W-HSAD_W){1'b0}}, half_sum};
      default: begin
        next_result = '0;
        op_reserved = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/pmsad_unit.sv
module pmsad_unit
  import pmsad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic              signed_sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  logic [LANES-1:0][DATA_W-1:0] lane_prod;
  logic [BSAD_W-1:0]            byte_sum;
  logic [HSAD_W-1:0]            half_sum;
  logic [DATA_W-1:0]            next_result;
  logic                         op_reserved;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pmsad_lane_mul u_mul (
      .x        (a[g*LANE_W +: LANE_W]),
      .y        (b[g*LANE_W +: LANE_W]),
      .sgn      (signed_sel),
      .prod_ext (lane_prod[g])
    );
  end

  pmsad_sad u_sad (
    .a        (a),
    .b        (b),
    .byte_sum (byte_sum),
    .half_sum (half_sum)
  );

  pmsad_select u_sel (
    .op          (op),
    .lane_prod   (lane_prod),
    .byte_sum    (byte_sum),
    .half_sum    (half_sum),
    .next_result (next_result),
    .op_reserved (op_reserved)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_result;
    end
  end
endmodule

// File: rtl/pmsad_checker.sv
module pmsad_checker
  import pmsad_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [OP_W-1:0]   op,
  input logic              signed_sel,
  input logic              op_reserved,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_reserved) |=> (result == '0));

  p_sadb_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SADB) |=> (result[DATA_W-1:BSAD_W] == '0));

  p_sadh_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SADH) |=> (result[DATA_W-1:HSAD_W] == '0));

  p_mac_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_MAC && signed_sel) |=>
      (result[DATA_W-1:PROD_W+1] == '0 || result[DATA_W-1:PROD_W+1] == '1));

  p_mac_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_MAC && !signed_sel) |=> (result[DATA_W-1:PROD_W+2] == '0));

  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r11: assert (!out_valid && result == '0);
    end
  end
endmodule

bind pmsad_unit pmsad_checker i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .op          (op),
  .signed_sel  (signed_sel),
  .op_reserved (op_reserved),
  .out_valid   (out_valid),
  .result      (result)
);

// File: tb/test_pmsad_unit.sv
`timescale 1ns/1ps
module test_pmsad_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        signed_sel = 1'b0;
  logic [63:0] a = 64'd0;
  logic [63:0] b = 64'd0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pmsad_unit i_pmsad_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .signed_sel(signed_sel), .a(a), .b(b),
    .out_valid(out_valid), .result(result)
  );

  function automatic longint lane_val(input logic [63:0] v, input int i, input bit sg);
    logic [15:0] h;
    h = v[16*i +: 16];
    if (sg) return longint'(shortint'(h));
    return longint'({48'd0, h});
  endfunction

  function automatic logic [63:0] model(input logic [2:0] opc, input bit sg,
                                        input logic [63:0] x, input logic [63:0] y);
    longint pr [4];
    logic [63:0] r;
    longint acc;
    r = 64'd0;
    for (int i = 0; i < 4; i++) pr[i] = lane_val(x, i, sg) * lane_val(y, i, sg);
    case (opc)
      3'd0: begin
        acc = pr[0] + pr[1];
        r[31:0] = acc[31:0];
        acc = pr[2] + pr[3];
        r[63:32] = acc[31:0];
      end
      3'd1: for (int i = 0; i < 4; i++) r[16*i +: 16] = pr[i][15:0];
      3'd2: for (int i = 0; i < 4; i++) r[16*i +: 16] = pr[i][31:16];
      3'd3: r = pr[0] + pr[1] + pr[2] + pr[3];
      3'd4: begin
        acc = 0;
        for (int i = 0; i < 8; i++) begin
          int d;
          d = int'(x[8*i +: 8]) - int'(y[8*i +: 8]);
          acc += (d < 0) ? -d : d;
        end
        r = acc;
      end
      3'd5: begin
        acc = 0;
        for (int i = 0; i < 4; i++) begin
          int d;
          d = int'(x[16*i +: 16]) - int'(y[16*i +: 16]);
          acc += (d < 0) ? -d : d;
        end
        r = acc;
      end
      default: r = 64'd0;
    endcase
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one valid operation and check both the result and out_valid.
  task automatic issue(input logic [2:0] opc, input bit sg, input logic [63:0] x,
                       input logic [63:0] y, input logic [63:0] exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; op = opc; signed_sel = sg; a = x; b = y;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R9 out_valid after valid", {63'd0, out_valid}, 64'd1);
    check(result == exp, req, result, exp);
  endtask

  task automatic t_reset;
    #5;
    check(out_valid == 1'b0, "R11 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check(result == 64'd0, "R11 result in reset", result, 64'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R11 idle after reset", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_madd;
    issue(3'd0, 1'b1, {4{16'h8000}}, {4{16'h8000}}, 64'h80000000_80000000, "R1 madd signed 0x8000");
    issue(3'd0, 1'b0, {4{16'hFFFF}}, {4{16'hFFFF}}, 64'hFFFC0002_FFFC0002, "R1 madd unsigned truncation");
    issue(3'd0, 1'b1, {4{16'hFFFF}}, {4{16'hFFFF}}, 64'h00000002_00000002, "R2 madd signed all-ones");
    issue(3'd0, 1'b0, 64'h0000_0000_0003_0002, 64'h0000_0000_0005_0004, 64'h00000000_00000017,
          "R1 madd low pair only");
  endtask

  task automatic t_mul_halves;
    issue(3'd1, 1'b1, {4{16'h8000}}, {4{16'h8000}}, 64'h0, "R3 mullo 0x8000");
    issue(3'd2, 1'b1, {4{16'h8000}}, {4{16'h8000}}, {4{16'h4000}}, "R4 mulhi signed 0x8000");
    issue(3'd2, 1'b0, {4{16'hFFFF}}, {4{16'hFFFF}}, {4{16'hFFFE}}, "R4 mulhi unsigned all-ones");
    issue(3'd2, 1'b1, {4{16'hFFFF}}, {4{16'h0002}}, {4{16'hFFFF}}, "R2 mulhi signed negative");
    issue(3'd1, 1'b0, {4{16'hFFFF}}, {4{16'hFFFF}}, {4{16'h0001}}, "R3 mullo unsigned all-ones");
  endtask

  task automatic t_mac;
    issue(3'd3, 1'b1, {4{16'h8000}}, {4{16'h8000}}, 64'h0000_0001_0000_0000, "R5 mac signed 0x8000");
    issue(3'd3, 1'b0, {4{16'hFFFF}}, {4{16'hFFFF}}, 64'h0000_0003_FFF8_0004, "R5 mac unsigned all-ones");
    issue(3'd3, 1'b1, {4{16'hFFFF}}, {4{16'h0001}}, 64'hFFFF_FFFF_FFFF_FFFC, "R5 mac signed negative sext");
    issue(3'd3, 1'b0, {4{16'hFFFF}}, {4{16'h0001}}, 64'h0000_0000_0003_FFFC, "R2 mac unsigned zext lanes");
  endtask

  task automatic t_sad;
    issue(3'd4, 1'b0, {8{8'hFF}}, 64'd0, 64'h7F8, "R6 sadb max");
    issue(3'd4, 1'b1, {8{8'hFF}}, 64'd0, 64'h7F8, "R6 sadb sign ignored");
    issue(3'd4, 1'b0, 64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, 64'd32, "R6 sadb mixed");
    issue(3'd5, 1'b0, 64'd0, {4{16'hFFFF}}, 64'h3FFFC, "R7 sadh max");
    issue(3'd5, 1'b1, 64'd0, {4{16'hFFFF}}, 64'h3FFFC, "R7 sadh sign ignored");
  endtask

  task automatic t_reserved;
    issue(3'd6, 1'b0, {4{16'h1234}}, {4{16'h5678}}, 64'd0, "R8 op 6 reserved");
    issue(3'd7, 1'b1, {4{16'hFFFF}}, {4{16'hFFFF}}, 64'd0, "R8 op 7 reserved");
  endtask

  task automatic t_hold;
    logic [63:0] keep;
    keep = 64'h0000_0000_0000_0017;
    issue(3'd0, 1'b0, 64'h0000_0000_0003_0002, 64'h0000_0000_0005_0004, keep, "R1 madd before hold");
    for (int k = 0; k < 3; k++) begin
      in_valid = 1'b0; op = 3'(k + 1); signed_sel = k[0];
      a = {4{16'hFFFF}}; b = {4{16'h8000}};
      @(negedge clk);
      check(result == keep, "R10 result held while idle", result, keep);
      check(out_valid == 1'b0, "R9 out_valid low while idle", {63'd0, out_valid}, 64'd0);
    end
  endtask

  task automatic t_random;
    for (int o = 0; o < 6; o++) begin
      for (int s = 0; s < 2; s++) begin
        for (int n = 0; n < 30; n++) begin
          logic [63:0] x, y;
          x = {$urandom, $urandom};
          y = {$urandom, $urandom};
          issue(3'(o), s[0], x, y, model(3'(o), s[0], x, y), "R2 random vs model");
        end
      end
    end
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_madd();
    t_mul_halves();
    t_mac();
    t_sad();
    t_reserved();
    t_hold();
    t_random();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule